// File: doc/BRIEF.md
# Register-Mapped Multiply/Divide Unit

This block is an arithmetic peripheral that sits behind a byte-wide write port of a processor. Software loads operand bytes into a small set of registers. The unit then computes either an unsigned 8×8 product or an unsigned 16÷8 quotient and remainder. The write of the last operand starts the operation, so no separate command register exists. A multiply starts when the multiplier byte is written. A divide starts when the divisor byte is written.

The arithmetic is sequential rather than combinational. A shift-add loop runs for one step per operand bit to form the product. A restoring loop runs for one step per dividend bit to form the quotient. A busy output stays high for the whole operation. Two 16-bit result outputs are always visible:

- The quotient.
- A shared result, which holds the product after a multiply or the remainder after a divide.

A new trigger write restarts the unit at once. Any operation that is still running is dropped.

Top module: `arith_muldiv_regs`

## Requirements
- R1: The write port selects a register with `wr_sel`. The codes are: 0 = multiplicand, 1 = multiplier, 2 = dividend low byte, 3 = dividend high byte, 4 = divisor. The low and high dividend bytes form one 16-bit dividend.
- R2: A write to code 1 starts an unsigned multiply of the stored multiplicand by the written byte. When busy falls, `res_o` holds the 16-bit product.
- R3: A write to code 4 with a nonzero byte starts an unsigned divide of the stored dividend by that byte. When busy falls, `quot_o` holds the quotient and `res_o` holds the remainder in its low byte, with its high byte zero.
- R4: Writes to codes 0, 2 and 3 start nothing. While the unit is idle, such writes leave `busy_o`, `quot_o` and `res_o` unchanged.
- R5: `busy_o` rises on the clock edge that takes a trigger write. It stays high for exactly 8 cycles for a multiply and 16 cycles for a divide.
- R6: A divide by zero still holds busy for 16 cycles. It then gives `quot_o` = 0xFFFF and `res_o` equal to the dividend.
- R7: A trigger write while busy cancels the running operation. The new operation restarts with its full cycle count, and only its result appears.
- R8: After synchronous reset, `busy_o`, `quot_o` and `res_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| wr_sel | input | 3 | Register select code (see R1) |
| wr_data | input | 8 | Write data byte |
| busy_o | output | 1 | High while an operation runs |
| quot_o | output | 16 | Quotient register |
| res_o | output | 16 | Product or remainder register |

## Verification
The multiply is tried with these operand patterns:

- A zero operand, which isolates the case where no partial product is added.
- 0xFF × 0xFF, which carries into the top product bit.
- A mixed pattern that exercises alternate adds and skips.

The divide is tried with these patterns:

- A full-scale dividend over 0xFF, which gives an exact quotient.
- A mid-range case that leaves a nonzero remainder.
- A dividend smaller than the divisor, which gives a zero quotient.
- A zero divisor, which shows the saturation path apart from the normal restoring path.

A divide cancelled part way by a multiply shows whether stale state from the dropped operation leaks into the new result.

// File: rtl/arith_pkg.sv
// Package: shared codes for the multiply/divide unit.
// Assumes a 3-bit register select on the write port.
package arith_pkg;

    // Register select codes; the multiplier and divisor codes act as triggers.
    typedef enum logic [2:0] {
        SEL_MCAND  = 3'd0,
        SEL_MPLIER = 3'd1,
        SEL_DVD_LO = 3'd2,
        SEL_DVD_HI = 3'd3,
        SEL_DVSR   = 3'd4
    } reg_sel_e;

    // Datapath operating mode.
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_MUL  = 2'd1,
        MODE_DIV  = 2'd2,
        MODE_DZ   = 2'd3
    } op_mode_e;

endpackage

// File: rtl/arith_operand_regs.sv
// Operand register file. It stores the multiplicand and the two dividend bytes,
// and decodes the trigger writes into single-cycle start pulses.
// Assumes one byte write per cycle. The trigger byte itself goes to the
// datapath through op_byte and is not stored here.
module arith_operand_regs
    import arith_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [OPW-1:0]   wr_data,
    output logic [OPW-1:0]   mcand,
    output logic [2*OPW-1:0] dividend,
    output logic [OPW-1:0]   op_byte,
    output logic             go_mul,
    output logic             go_div
);

    // Decode the trigger writes; they take effect at the same edge.
    always_comb begin
        go_mul  = wr_en && (wr_sel == SEL_MPLIER);
        go_div  = wr_en && (wr_sel == SEL_DVSR);
        op_byte = wr_data;
    end

    // Capture the non-trigger operand bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand    <= '0;
            dividend <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MCAND:  mcand               <= wr_data;
                SEL_DVD_LO: dividend[OPW-1:0]   <= wr_data;
                SEL_DVD_HI: dividend[2*OPW-1:OPW] <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/arith_step_ctrl.sv
// Step sequencer. It raises busy on a start pulse and counts one step per cycle.
// It drops busy after OPW steps for a multiply or 2*OPW steps for a divide.
// Assumes that a start pulse always takes priority and restarts the count.
module arith_step_ctrl #(
    parameter int OPW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_mul,
    input  logic go_div,
    output logic busy
);

    localparam int CW = $clog2(2 * OPW + 1);
    localparam logic [CW-1:0] MUL_LAST = CW'(OPW - 1);
    localparam logic [CW-1:0] DIV_LAST = CW'(2 * OPW - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Count steps and clear busy after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            last <= '0;
        end else if (go_mul || go_div) begin
            busy <= 1'b1;
            cnt  <= '0;
            last <= go_div ? DIV_LAST : MUL_LAST;
        end else if (busy) begin
            if (cnt == last) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/arith_datapath.sv
// Arithmetic datapath. It does a shift-add multiply and a restoring divide,
// one bit per step_en cycle. The result register doubles as the product
// accumulator and the partial remainder, and the quotient register shifts
// in the quotient bits.
// Assumes step_en is high for exactly the number of steps the operation needs.
module arith_datapath
    import arith_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_mul,
    input  logic             go_div,
    input  logic             step_en,
    input  logic [OPW-1:0]   mcand,
    input  logic [OPW-1:0]   op_byte,
    input  logic [2*OPW-1:0] dividend,
    output logic [2*OPW-1:0] quot,
    output logic [2*OPW-1:0] res
);

    localparam int RW = 2 * OPW;

    op_mode_e       mode;
    logic [RW-1:0]  mc_sh;
    logic [OPW-1:0] mp_sh;
    logic [OPW-1:0] dvsr;
    logic [OPW:0]   trial;
    logic [OPW:0]   diff;
    logic           fits;

    // Form the restoring trial subtraction for one divide step.
    always_comb begin
        trial = {res[OPW-1:0], quot[RW-1]};
        diff  = trial - {1'b0, dvsr};
        fits  = (trial >= {1'b0, dvsr});
    end

    // Load operands on a start pulse, else advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_IDLE;
            mc_sh <= '0;
            mp_sh <= '0;
            dvsr  <= '0;
            quot  <= '0;
            res   <= '0;
        end else if (go_mul) begin
            mode  <= MODE_MUL;
            mc_sh <= {{OPW{1'b0}}, mcand};
            mp_sh <= op_byte;
            quot  <= {{OPW{1'b0}}, mcand};
            res   <= '0;
        end else if (go_div) begin
            dvsr <= op_byte;
            if (op_byte == '0) begin
                mode <= MODE_DZ;
                quot <= '1;
                res  <= dividend;
            end else begin
                mode <= MODE_DIV;
                quot <= dividend;
                res  <= '0;
            end
        end else if (step_en) begin
            case (mode)
                MODE_MUL: begin
                    if (mp_sh[0]) res <= res + mc_sh;
                    mc_sh <= mc_sh << 1;
                    mp_sh <= mp_sh >> 1;
                end
                MODE_DIV: begin
                    res  <= {{OPW{1'b0}}, (fits ? diff[OPW-1:0] : trial[OPW-1:0])};
                    quot <= {quot[RW-2:0], fits};
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/arith_muldiv_regs.sv
// Top of the register-mapped multiply/divide unit. It ties together the
// operand registers, the step sequencer and the arithmetic datapath.
// Assumes a single writer with one-cycle write strobes.
module arith_muldiv_regs #(
    parameter int OPW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [OPW-1:0]   wr_data,
    output logic             busy_o,
    output logic [2*OPW-1:0] quot_o,
    output logic [2*OPW-1:0] res_o
);

    logic [OPW-1:0]   mcand;
    logic [2*OPW-1:0] dividend;
    logic [OPW-1:0]   op_byte;
    logic             go_mul;
    logic             go_div;

    arith_operand_regs #(.OPW(OPW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .mcand    (mcand),
        .dividend (dividend),
        .op_byte  (op_byte),
        .go_mul   (go_mul),
        .go_div   (go_div)
    );

    arith_step_ctrl #(.OPW(OPW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_mul (go_mul),
        .go_div (go_div),
        .busy   (busy_o)
    );

    arith_datapath #(.OPW(OPW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_mul   (go_mul),
        .go_div   (go_div),
        .step_en  (busy_o),
        .mcand    (mcand),
        .op_byte  (op_byte),
        .dividend (dividend),
        .quot     (quot_o),
        .res      (res_o)
    );

endmodule

// File: rtl/arith_muldiv_regs_chk.sv
// Checker for the multiply/divide unit. It keeps its own shadow of the
// multiplicand, the operation length and a cycle counter, and checks the
// port behaviour against them.
module arith_muldiv_regs_chk #(
    parameter int OPW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [OPW-1:0]   wr_data,
    input logic             busy_o,
    input logic [2*OPW-1:0] quot_o,
    input logic [2*OPW-1:0] res_o
);

    localparam int RW = 2 * OPW;

    logic          trig_mul;
    logic          trig_div;
    logic          trig;
    logic [OPW-1:0] mc_seen;
    logic [RW-1:0] exp_prod;
    logic [5:0]    cnt;
    logic [5:0]    len;
    logic          kind_mul;
    logic          kind_dz;

    // Decode trigger writes from the port codes.
    always_comb begin
        trig_mul = wr_en && (wr_sel == 3'd1);
        trig_div = wr_en && (wr_sel == 3'd4);
        trig     = trig_mul || trig_div;
    end

    // Track operands, the operation kind and the busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_seen  <= '0;
            exp_prod <= '0;
            cnt      <= '0;
            len      <= '0;
            kind_mul <= 1'b0;
            kind_dz  <= 1'b0;
        end else begin
            if (wr_en && wr_sel == 3'd0) mc_seen <= wr_data;
            if (trig) begin
                cnt      <= '0;
                len      <= trig_div ? 6'(RW) : 6'(OPW);
                kind_mul <= trig_mul;
                kind_dz  <= trig_div && (wr_data == '0);
                exp_prod <= {{OPW{1'b0}}, mc_seen} * {{OPW{1'b0}}, wr_data};
            end else if (busy_o) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r5_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> busy_o);

    a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (cnt == len));

    a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && kind_mul) |-> (res_o == exp_prod));

    a_r6_div_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && kind_dz) |-> (quot_o == '1));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !trig) |=> ($stable(quot_o) && $stable(res_o) && !busy_o));

endmodule

bind arith_muldiv_regs arith_muldiv_regs_chk #(.OPW(OPW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .busy_o  (busy_o),
    .quot_o  (quot_o),
    .res_o   (res_o)
);

// File: tb/test_arith_muldiv_regs.sv
// Scoreboard bench: driver tasks queue the expected results and a monitor
// compares them when busy falls.
module test_arith_muldiv_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        busy_o;
    logic [15:0] quot_o;
    logic [15:0] res_o;

    typedef struct {
        string      tag;
        bit         chk_q;
        logic [15:0] q;
        logic [15:0] r;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic prev_busy = 1'b0;

    always #2.5 clk = ~clk;

    arith_muldiv_regs i_arith_muldiv_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy_o(busy_o), .quot_o(quot_o), .res_o(res_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count busy cycles after a trigger write, until busy drops.
    task automatic wait_len(string tag, int exp_len);
        int n = 0;
        while (busy_o === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(tag, n, exp_len);
    endtask

    task automatic do_mul(logic [7:0] a, logic [7:0] b, string tag);
        exp_t e;
        e.tag = tag; e.chk_q = 1'b0; e.q = '0; e.r = 16'(a) * 16'(b);
        wr(3'd0, a);
        sb.push_back(e);
        wr(3'd1, b);
        wait_len({tag, " R5 mul length"}, 8);
        @(negedge clk);
    endtask

    task automatic do_div(logic [15:0] dvd, logic [7:0] d, string tag);
        exp_t e;
        e.tag = tag; e.chk_q = 1'b1;
        if (d == 0) begin
            e.q = 16'hFFFF; e.r = dvd;
        end else begin
            e.q = dvd / 16'(d); e.r = dvd % 16'(d);
        end
        wr(3'd2, dvd[7:0]);
        wr(3'd3, dvd[15:8]);
        sb.push_back(e);
        wr(3'd4, d);
        wait_len({tag, " R5 div length"}, 16);
        @(negedge clk);
    endtask

    // Monitor: on each falling busy, pop the expected result and compare.
    always @(negedge clk) begin
        if (rst_n && prev_busy && !busy_o) begin
            if (sb.size() == 0) begin
                check("R7 unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " result"}, {16'h0, res_o}, {16'h0, e.r});
                if (e.chk_q) check({e.tag, " quotient"}, {16'h0, quot_o}, {16'h0, e.q});
            end
        end
        prev_busy = busy_o;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset busy", {31'h0, busy_o}, 0);
        check("R8 reset quot", {16'h0, quot_o}, 0);
        check("R8 reset res", {16'h0, res_o}, 0);

        do_mul(8'h00, 8'h5A, "R2 zero multiplicand");
        do_mul(8'hFF, 8'hFF, "R2 full scale");
        do_mul(8'h12, 8'h34, "R2 mixed bits");

        do_div(16'hFFFF, 8'hFF, "R1/R3 full-scale dividend");
        do_div(16'd1000, 8'd7, "R3 with remainder");
        do_div(16'd5, 8'd200, "R3 small dividend");
        do_div(16'h1234, 8'h00, "R6 divide by zero");

        // R4: non-trigger writes while idle change nothing visible.
        begin
            logic [15:0] q0, r0;
            q0 = quot_o; r0 = res_o;
            wr(3'd2, 8'hAA);
            wr(3'd3, 8'h55);
            wr(3'd0, 8'h77);
            @(negedge clk);
            check("R4 busy stays low", {31'h0, busy_o}, 0);
            check("R4 quot held", {16'h0, quot_o}, {16'h0, q0});
            check("R4 res held", {16'h0, res_o}, {16'h0, r0});
        end

        // R7: a divide cancelled by a multiply; only the multiply completes.
        begin
            exp_t e;
            wr(3'd2, 8'h10);
            wr(3'd3, 8'h27);
            wr(3'd4, 8'h03);
            repeat (3) @(negedge clk);
            wr(3'd0, 8'h0B);
            e.tag = "R7 cancel by new trigger"; e.chk_q = 1'b0; e.q = '0;
            e.r = 16'd143;
            sb.push_back(e);
            wr(3'd1, 8'h0D);
            wait_len("R7 restarted length", 8);
            @(negedge clk);
        end

        check("R7 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule